// File: doc/BRIEF.md
# LPC Host Request Front End

This block is the register face of an LPC host controller. A processor programs one batch of I/O cycles through a small memory-mapped window. A batch is made of a cycle count, a direction, an address-increment policy and a 16-bit port number. For a write batch, the processor also loads the outgoing bytes into a byte queue. It then launches the batch, polls a two-bit status word, and for a read batch drains the returned bytes from a second queue.

The block does not drive the LPC wires. It hands a request bundle and a one-cycle launch pulse to a separate cycle engine. While the engine runs, the engine pops outgoing bytes from the transmit queue and pushes incoming bytes into the receive queue. When it signals completion, the block records whether the batch succeeded. The status word reads idle plus finished after a good batch. It reads idle with finished clear after a failed or rejected batch.

Top module: `lpc_req_frontend`

## Requirements
- R1: After reset, the status word (offset 0x04) reads 1: bit 0 (idle) is 1 and bit 1 (finished) is 0. Both queues are empty, and a load from the receive queue returns 0.
- R2: Writing a value with bit 0 set to offset 0x00 while idle, with a valid cycle count, raises `eng_start` for exactly one cycle, in the cycle after the write. From that write onward, the status word reads 0 until completion.
- R3: The request bundle reflects the programmed registers. `eng_write` is bit 0 of the command register at 0x14 (1 = write). `eng_same_addr` is bit 3 of that register. `eng_port_addr` is the port register at 0x20. `eng_count` is the count register at 0x10. Writes to these registers are ignored while a batch is in flight.
- R4: Each byte stored to offset 0x24 enters the transmit queue, which holds 4 bytes. `eng_wr_byte` shows the oldest byte, or 0 when the queue is empty. `eng_wr_pop` advances the queue. Stores made while the queue is full are dropped.
- R5: `eng_rd_push` places `eng_rd_byte` in the 4-byte receive queue, and pushes made while it is full are dropped. Loads from offset 0x28 return the bytes oldest first and remove them. A load from an empty queue returns 0.
- R6: An `eng_done` pulse during a batch makes the status word read 3 when `eng_err` is 0, and 1 when `eng_err` is 1.
- R7: A launch write made while a batch is in flight is ignored: no further `eng_start` pulse, and the receive queue is not emptied.
- R8: A launch with a cycle count of 0 or greater than 4 never raises `eng_start`, and the status word reads 1 immediately afterwards.
- R9: An accepted launch empties the receive queue. Completion of a batch discards any transmit bytes the engine did not pop.
- R10: Loads from offsets other than 0x04, 0x10, 0x14, 0x20 and 0x28 return 0. Writing offset 0x00 with bit 0 clear has no effect.
- R11: An accepted launch clears the finished bit left by the previous batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register store strobe |
| reg_rd_en | input | 1 | Register load strobe (pops the receive queue at 0x28) |
| reg_addr | input | ADDR_W | Byte offset within the window |
| reg_wdata | input | DATA_W | Store data |
| reg_rdata | output | DATA_W | Load data for `reg_addr`, combinational |
| eng_start | output | 1 | One-cycle launch pulse to the cycle engine |
| eng_write | output | 1 | Batch direction, 1 = write |
| eng_same_addr | output | 1 | Every cycle of the batch uses the same port |
| eng_port_addr | output | PORT_W | Target port number |
| eng_count | output | LEN_W | Cycles in the batch |
| eng_wr_pop | input | 1 | Engine consumes one transmit byte |
| eng_wr_byte | output | 8 | Oldest transmit byte |
| eng_rd_push | input | 1 | Engine delivers one receive byte |
| eng_rd_byte | input | 8 | Receive byte |
| eng_done | input | 1 | Batch complete pulse |
| eng_err | input | 1 | Batch failed, qualified by `eng_done` |

## Verification
The bench builds the block with its default parameters: 4-byte queues, a cycle limit of 4, an 8-bit offset and a 16-bit port number. With these values, five pushes are enough to fill either queue and show the overflow drop. A count of 5 is the first length past the limit. The single count register can hold both out-of-range values, 0 and 5, so both rejection paths are reachable through it.

// File: rtl/lpcfe_pkg.sv
package lpcfe_pkg;
   // Register offsets within the window
   localparam logic [7:0] OFF_GO   = 8'h00;
   localparam logic [7:0] OFF_STAT = 8'h04;
   localparam logic [7:0] OFF_LEN  = 8'h10;
   localparam logic [7:0] OFF_CMD  = 8'h14;
   localparam logic [7:0] OFF_PORT = 8'h20;
   localparam logic [7:0] OFF_TXQ  = 8'h24;
   localparam logic [7:0] OFF_RXQ  = 8'h28;

   // Bit positions decoded by the cycle engine side
   localparam int CMD_DIR_BIT  = 0;
   localparam int CMD_SAME_BIT = 3;
   localparam int STAT_IDLE    = 0;
   localparam int STAT_DONE    = 1;
endpackage

// File: rtl/lpcfe_byte_fifo.sv
module lpcfe_byte_fifo #(
   parameter int DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       push,
   input  logic [7:0] din,
   input  logic       pop,
   output logic [7:0] head,
   output logic       full,
   output logic       empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam bit   IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

   initial begin
      a_depth_ok : assert (DEPTH >= 2 && DEPTH <= 256)
         else $error("lpcfe_byte_fifo: DEPTH out of range");
   end

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == FULL_CNT);
   assign empty   = (cnt == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = empty ? 8'h00 : mem[rd_ptr];

   generate
      if (IS_POW2) begin : g_wrap_free
         assign wr_nxt = PTR_W'(wr_ptr + 1'b1);
         assign rd_nxt = PTR_W'(rd_ptr + 1'b1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(wr_ptr + 1'b1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(rd_ptr + 1'b1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   // R4 / R5: a push into a full queue with no pop leaves it full and unchanged
   a_r4_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (full && $stable(rd_ptr)));
   // R9: a flush leaves the queue empty
   a_r9_flush_empties : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   // R5: a pop on an empty queue does not move the read side
   a_r5_empty_pop_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/lpcfe_seq.sv
module lpcfe_seq #(
   parameter int LEN_W   = 8,
   parameter int MAX_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_req,
   input  logic [LEN_W-1:0] len,
   input  logic             eng_done,
   input  logic             eng_err,
   output logic             busy,
   output logic             finished,
   output logic             eng_start,
   output logic             flush_rx,
   output logic             flush_tx
);
   initial begin
      a_len_fits : assert (MAX_LEN >= 1 && MAX_LEN < (1 << LEN_W))
         else $error("lpcfe_seq: MAX_LEN does not fit LEN_W");
   end

   logic accept, len_ok, launch, retire;

   assign accept   = go_req && !busy;
   assign len_ok   = (len != '0) && (len <= LEN_W'(MAX_LEN));
   assign launch   = accept && len_ok;
   assign retire   = eng_done && busy;
   assign flush_rx = accept;
   assign flush_tx = retire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         finished  <= 1'b0;
         eng_start <= 1'b0;
      end else begin
         eng_start <= launch;
         if (accept) begin
            busy     <= len_ok;
            finished <= 1'b0;
         end else if (retire) begin
            busy     <= 1'b0;
            finished <= !eng_err;
         end
      end
   end

   // R2: the launch pulse lasts a single cycle
   a_r2_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   // R2: the engine is only launched while a batch is in flight
   a_r2_start_busy : assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> busy);
   // R7: a launch request during a batch produces no pulse
   a_r7_busy_ignore : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && go_req && !eng_done) |=> (!eng_start && busy));
   // R6: completion returns to idle
   a_r6_done_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_done) |=> !busy);
   // R11: an accepted launch clears finished
   a_r11_clear_fin : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !finished);
endmodule

// File: rtl/lpc_req_frontend.sv
module lpc_req_frontend #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int PORT_W  = 16,
   parameter int LEN_W   = 8,
   parameter int MAX_LEN = 4,
   parameter int Q_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              eng_start,
   output logic              eng_write,
   output logic              eng_same_addr,
   output logic [PORT_W-1:0] eng_port_addr,
   output logic [LEN_W-1:0]  eng_count,
   input  logic              eng_wr_pop,
   output logic [7:0]        eng_wr_byte,
   input  logic              eng_rd_push,
   input  logic [7:0]        eng_rd_byte,
   input  logic              eng_done,
   input  logic              eng_err
);
   import lpcfe_pkg::*;

   initial begin
      a_widths_ok : assert (ADDR_W >= 6 && DATA_W >= PORT_W && DATA_W >= LEN_W
                            && DATA_W >= 8 && MAX_LEN <= Q_DEPTH)
         else $error("lpc_req_frontend: inconsistent parameters");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
      return a == ADDR_W'(off);
   endfunction

   logic busy, finished, flush_rx, flush_tx;
   logic go_req, tx_push, rx_pop;
   logic [7:0] rx_head;
   logic tx_full, tx_empty, rx_full, rx_empty;
   logic cfg_we;

   assign go_req  = reg_wr_en && hit(reg_addr, OFF_GO) && reg_wdata[0];
   assign tx_push = reg_wr_en && hit(reg_addr, OFF_TXQ);
   assign rx_pop  = reg_rd_en && hit(reg_addr, OFF_RXQ);
   assign cfg_we  = reg_wr_en && !busy;

   // Batch configuration, locked while a batch runs
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eng_count     <= '0;
         eng_write     <= 1'b0;
         eng_same_addr <= 1'b0;
         eng_port_addr <= '0;
      end else if (cfg_we) begin
         if (hit(reg_addr, OFF_LEN))  eng_count <= reg_wdata[LEN_W-1:0];
         if (hit(reg_addr, OFF_CMD)) begin
            eng_write     <= reg_wdata[CMD_DIR_BIT];
            eng_same_addr <= reg_wdata[CMD_SAME_BIT];
         end
         if (hit(reg_addr, OFF_PORT)) eng_port_addr <= reg_wdata[PORT_W-1:0];
      end
   end

   lpcfe_seq #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_req(go_req), .len(eng_count),
      .eng_done(eng_done), .eng_err(eng_err), .busy(busy), .finished(finished),
      .eng_start(eng_start), .flush_rx(flush_rx), .flush_tx(flush_tx)
   );

   lpcfe_byte_fifo #(.DEPTH(Q_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush_tx), .push(tx_push),
      .din(reg_wdata[7:0]), .pop(eng_wr_pop), .head(eng_wr_byte),
      .full(tx_full), .empty(tx_empty)
   );

   lpcfe_byte_fifo #(.DEPTH(Q_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush_rx), .push(eng_rd_push),
      .din(eng_rd_byte), .pop(rx_pop), .head(rx_head),
      .full(rx_full), .empty(rx_empty)
   );

   always_comb begin
      reg_rdata = '0;
      if (hit(reg_addr, OFF_STAT)) begin
         reg_rdata[STAT_IDLE] = !busy;
         reg_rdata[STAT_DONE] = finished;
      end else if (hit(reg_addr, OFF_LEN)) begin
         reg_rdata[LEN_W-1:0] = eng_count;
      end else if (hit(reg_addr, OFF_CMD)) begin
         reg_rdata[CMD_DIR_BIT]  = eng_write;
         reg_rdata[CMD_SAME_BIT] = eng_same_addr;
      end else if (hit(reg_addr, OFF_PORT)) begin
         reg_rdata[PORT_W-1:0] = eng_port_addr;
      end else if (hit(reg_addr, OFF_RXQ)) begin
         reg_rdata[7:0] = rx_head;
      end
   end

   // R8: the engine never receives an out-of-range cycle count
   a_r8_len_range : assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (eng_count != '0 && eng_count <= LEN_W'(MAX_LEN)));
   // R3: the request bundle holds still across a running batch
   a_r3_bundle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || ($stable(eng_port_addr) && $stable(eng_count)
                          && $stable(eng_write) && $stable(eng_same_addr))));
   // R4: an empty transmit queue presents zero to the engine
   a_r4_tx_zero : assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> (eng_wr_byte == 8'h00));
   // R9: the receive queue is empty right after a launch is accepted
   a_r9_rx_flushed : assert property (@(posedge clk) disable iff (!rst_n)
      (go_req && !busy) |=> rx_empty);
   // R5: receive queue full and empty are never both set
   a_r5_rx_flags : assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_full && rx_empty) && !(tx_full && tx_empty));
endmodule

// File: tb/sim_lpc_req_frontend.sv
`timescale 1ns/1ps
module sim_lpc_req_frontend;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_start, eng_write, eng_same_addr;
   logic [15:0] eng_port_addr;
   logic [7:0]  eng_count;
   logic        eng_wr_pop = 1'b0;
   logic [7:0]  eng_wr_byte;
   logic        eng_rd_push = 1'b0;
   logic [7:0]  eng_rd_byte = '0;
   logic        eng_done = 1'b0, eng_err = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   lpc_req_frontend u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_start(eng_start), .eng_write(eng_write), .eng_same_addr(eng_same_addr),
      .eng_port_addr(eng_port_addr), .eng_count(eng_count),
      .eng_wr_pop(eng_wr_pop), .eng_wr_byte(eng_wr_byte),
      .eng_rd_push(eng_rd_push), .eng_rd_byte(eng_rd_byte),
      .eng_done(eng_done), .eng_err(eng_err)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr_en = 1'b0; reg_wdata = '0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      reg_rd_en = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      tick();
      reg_rd_en = 1'b0;
   endtask

   task automatic tx_pop(output logic [7:0] b);
      eng_wr_pop = 1'b1;
      #1 b = eng_wr_byte;
      tick();
      eng_wr_pop = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      eng_rd_push = 1'b1; eng_rd_byte = b;
      tick();
      eng_rd_push = 1'b0;
   endtask

   task automatic finish_batch(input logic err);
      eng_done = 1'b1; eng_err = err;
      tick();
      eng_done = 1'b0; eng_err = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_rd(8'h04, d);  check("R1 status after reset", d, 32'h1);
      bus_rd(8'h28, d);  check("R1 empty rx load", d, 32'h0);
      check("R1 no launch", {31'b0, eng_start}, 32'h0);
      check("R1 tx head empty", {24'b0, eng_wr_byte}, 32'h0);
   endtask

   task automatic t_write_batch();
      logic [31:0] d; logic [7:0] b;
      bus_wr(8'h10, 32'd3);
      bus_wr(8'h14, 32'h1);
      bus_wr(8'h20, 32'h1234);
      bus_wr(8'h24, 32'hAA); bus_wr(8'h24, 32'hBB); bus_wr(8'h24, 32'hCC);
      bus_wr(8'h00, 32'h1);
      check("R2 launch pulse", {31'b0, eng_start}, 32'h1);
      check("R3 direction", {31'b0, eng_write}, 32'h1);
      check("R3 same addr", {31'b0, eng_same_addr}, 32'h0);
      check("R3 port", {16'b0, eng_port_addr}, 32'h1234);
      check("R3 count", {24'b0, eng_count}, 32'd3);
      bus_rd(8'h04, d);
      check("R2 pulse one cycle", {31'b0, eng_start}, 32'h0);
      check("R2 status busy", d, 32'h0);
      bus_wr(8'h20, 32'h5555);
      check("R3 port locked while busy", {16'b0, eng_port_addr}, 32'h1234);
      tx_pop(b); check("R4 byte 0", {24'b0, b}, 32'hAA);
      tx_pop(b); check("R4 byte 1", {24'b0, b}, 32'hBB);
      tx_pop(b); check("R4 byte 2", {24'b0, b}, 32'hCC);
      check("R4 empty head", {24'b0, eng_wr_byte}, 32'h0);
      finish_batch(1'b0);
      bus_rd(8'h04, d); check("R6 success status", d, 32'h3);
   endtask

   task automatic t_read_batch();
      logic [31:0] d;
      bus_wr(8'h10, 32'd2);
      bus_wr(8'h14, 32'h8);
      bus_wr(8'h00, 32'h1);
      check("R3 read direction", {31'b0, eng_write}, 32'h0);
      check("R3 same addr set", {31'b0, eng_same_addr}, 32'h1);
      bus_rd(8'h14, d); check("R3 cmd readback", d, 32'h8);
      rx_push(8'h11); rx_push(8'h22);
      finish_batch(1'b0);
      bus_rd(8'h04, d); check("R6 read ok status", d, 32'h3);
      bus_rd(8'h28, d); check("R5 rx byte 0", d, 32'h11);
      bus_rd(8'h28, d); check("R5 rx byte 1", d, 32'h22);
      bus_rd(8'h28, d); check("R5 rx drained", d, 32'h0);
   endtask

   task automatic t_overflow();
      logic [31:0] d; logic [7:0] b;
      bus_wr(8'h10, 32'd4);
      bus_wr(8'h14, 32'h1);
      for (int i = 1; i <= 5; i++) bus_wr(8'h24, 32'(i));
      bus_wr(8'h00, 32'h1);
      for (int i = 1; i <= 4; i++) begin
         tx_pop(b); check("R4 tx order under overflow", {24'b0, b}, 32'(i));
      end
      check("R4 fifth byte dropped", {24'b0, eng_wr_byte}, 32'h0);
      finish_batch(1'b0);
      bus_wr(8'h14, 32'h0);
      bus_wr(8'h00, 32'h1);
      for (int i = 1; i <= 5; i++) rx_push(8'(8'h40 + i));
      finish_batch(1'b0);
      for (int i = 1; i <= 4; i++) begin
         bus_rd(8'h28, d); check("R5 rx order under overflow", d, 32'(8'h40 + i));
      end
      bus_rd(8'h28, d); check("R5 fifth rx dropped", d, 32'h0);
   endtask

   task automatic t_error();
      logic [31:0] d;
      bus_wr(8'h10, 32'd1);
      bus_wr(8'h00, 32'h1);
      finish_batch(1'b1);
      bus_rd(8'h04, d); check("R6 error status", d, 32'h1);
   endtask

   task automatic t_busy_start();
      logic [31:0] d;
      bus_wr(8'h10, 32'd1);
      bus_wr(8'h14, 32'h0);
      bus_wr(8'h00, 32'h1);
      rx_push(8'h77);
      bus_wr(8'h00, 32'h1);
      check("R7 no second pulse", {31'b0, eng_start}, 32'h0);
      tick();
      check("R7 still no pulse", {31'b0, eng_start}, 32'h0);
      finish_batch(1'b0);
      bus_rd(8'h28, d); check("R7 rx kept", d, 32'h77);
   endtask

   task automatic t_bad_len();
      logic [31:0] d;
      logic seen;
      bus_wr(8'h10, 32'd0);
      bus_wr(8'h00, 32'h1);
      seen = eng_start;
      bus_rd(8'h04, d);
      check("R8 len 0 no launch", {31'b0, seen | eng_start}, 32'h0);
      check("R8 len 0 status", d, 32'h1);
      bus_wr(8'h10, 32'd5);
      bus_wr(8'h00, 32'h1);
      seen = eng_start;
      bus_rd(8'h04, d);
      check("R8 len 5 no launch", {31'b0, seen | eng_start}, 32'h0);
      check("R8 len 5 status", d, 32'h1);
   endtask

   task automatic t_flush();
      logic [31:0] d;
      bus_wr(8'h10, 32'd1);
      bus_wr(8'h14, 32'h0);
      bus_wr(8'h00, 32'h1);
      rx_push(8'h5A);
      finish_batch(1'b0);
      bus_wr(8'h00, 32'h1);
      finish_batch(1'b0);
      bus_rd(8'h28, d); check("R9 stale rx flushed", d, 32'h0);
      bus_wr(8'h14, 32'h1);
      bus_wr(8'h24, 32'h61); bus_wr(8'h24, 32'h62); bus_wr(8'h24, 32'h63);
      bus_wr(8'h00, 32'h1);
      tx_pop(d[7:0]);
      check("R9 first tx byte", {24'b0, d[7:0]}, 32'h61);
      finish_batch(1'b0);
      check("R9 leftover tx discarded", {24'b0, eng_wr_byte}, 32'h0);
   endtask

   task automatic t_fin_clear();
      logic [31:0] d;
      bus_rd(8'h04, d); check("R11 prior finished", d, 32'h3);
      bus_wr(8'h10, 32'd2);
      bus_wr(8'h00, 32'h1);
      bus_rd(8'h04, d); check("R11 finished cleared", d, 32'h0);
      finish_batch(1'b0);
   endtask

   task automatic t_undef();
      logic [31:0] d;
      bus_rd(8'h08, d); check("R10 offset 0x08", d, 32'h0);
      bus_rd(8'h30, d); check("R10 offset 0x30", d, 32'h0);
      bus_rd(8'h24, d); check("R10 offset 0x24 load", d, 32'h0);
      bus_rd(8'h00, d); check("R10 offset 0x00 load", d, 32'h0);
      bus_wr(8'h00, 32'h2);
      check("R10 bit0 clear no launch", {31'b0, eng_start}, 32'h0);
      bus_rd(8'h04, d); check("R10 status unchanged", d, 32'h3);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_write_batch();
      t_read_batch();
      t_overflow();
      t_error();
      t_busy_start();
      t_bad_len();
      t_flush();
      t_fin_clear();
      t_undef();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #400000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule